// File: doc/BRIEF.md
# Level-Sticky Masked Interrupt Controller

This block gathers 32 level-sensitive interrupt request lines into a single interrupt output for a processor. Each clock it samples the request lines into a level word. A line seen high sets its bit in a pending word, and that bit stays set after the line drops, until software acknowledges it. The output is raised whenever a pending bit is also enabled in a software-written mask word. An acknowledge cannot remove a line that is still being driven high, because the sampled levels are merged into the pending word again on the same update.

Software reaches the block through a plain word-addressed register port with a write strobe and an address-decoded read path. The port moves no data stream, so it has no valid/ready handshake and no back-pressure: a write takes effect at the clock edge where the strobe is high, and read data follows the address with no latency. The block also keeps a 32-bit event counter for each line that counts rising edges of that line. The counters are read through the same port. The request inputs are assumed to be synchronous to the clock already.

Top module: `lvl_sticky_intc`

## Requirements
- R1: Reset clears the mask, pending, level and all counter words to zero, and drives irq_o low.
- R2: A read at address 2 returns the level word: bit i equals request line i as sampled at the most recent clock edge.
- R3: Pending bit i is set at any edge where line i is high, and it stays set when the line later goes low, unless it is acknowledged.
- R4: irq_o is registered and equals the OR of (pending AND mask), so it changes one cycle after the input, mask write or acknowledge that causes the change.
- R5: A write to address 0 replaces the whole mask with the written data, and a read at address 0 returns it.
- R6: A write to address 1 clears each pending bit whose written bit is 1 and whose line is low at that edge. Bits written as 0 are left unchanged.
- R7: An acknowledge does not clear a pending bit whose line is high at the same edge, including a line that rises in that cycle.
- R8: A read at address 32+i returns the counter of line i. The counter increases by one at each edge where line i is high and was low at the previous edge. It does not count while the line is held high.
- R9: Writes to address 2 or to the counter addresses have no effect, and reads of unmapped addresses (3 to 31) return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 32 | Level-sensitive interrupt request lines, bit i is line i |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 6 | Word address for reads and writes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Merged interrupt output to the processor |

## Verification
The main function is driven with a sparse multi-bit request pattern followed by all lines low. This separates the sticky pending word from the live level word. Mask patterns are written that either cover or miss the pending bits, so the output cannot simply follow pending activity. Acknowledges are applied to lines that are low, to lines held high, and to a line that rises in the same cycle as its acknowledge. These three cases separate a plain write-one-to-clear from the merge that restores bits for asserted lines. The counters are exercised with a line pulsed twice and held high for several cycles, one pulse on the highest line, and an idle line. Together these show that only rising edges are counted, on the right line.

// File: rtl/lsic_pkg.sv
package lsic_pkg;
  // Word addresses of the register port
  localparam int unsigned ADDR_MASK  = 0;
  localparam int unsigned ADDR_PEND  = 1;
  localparam int unsigned ADDR_LEVEL = 2;
  localparam int unsigned CNT_BASE   = 32;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_MASK,
    SEL_PEND,
    SEL_LEVEL
  } reg_sel_e;
endpackage

// File: rtl/lsic_line_state.sv
module lsic_line_state #(
  parameter int unsigned NUM_LINES = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] req_i,
  input  logic [NUM_LINES-1:0] ack_i,
  output logic [NUM_LINES-1:0] lvl_q_o,
  output logic [NUM_LINES-1:0] pend_q_o,
  output logic [NUM_LINES-1:0] pend_d_o,
  output logic [NUM_LINES-1:0] rise_o
);
  logic [NUM_LINES-1:0] lvl_q;
  logic [NUM_LINES-1:0] pend_q;
  logic [NUM_LINES-1:0] pend_d;

  // Acknowledge first, then merge live levels back in
  always_comb begin
    pend_d = (pend_q & ~ack_i) | req_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= '0;
      pend_q <= '0;
    end else begin
      lvl_q  <= req_i;
      pend_q <= pend_d;
    end
  end

  assign rise_o   = req_i & ~lvl_q;
  assign lvl_q_o  = lvl_q;
  assign pend_q_o = pend_q;
  assign pend_d_o = pend_d;
endmodule

// File: rtl/lsic_event_counters.sv
module lsic_event_counters #(
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned CNT_W     = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_LINES-1:0]       rise_i,
  output logic [NUM_LINES*CNT_W-1:0] cnt_flat_o
);
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q <= '0;
      end else if (rise_i[g]) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end

    assign cnt_flat_o[g*CNT_W +: CNT_W] = cnt_q;
  end
endmodule

// File: rtl/lsic_reg_port.sv
module lsic_reg_port
  import lsic_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 6
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  input  logic [NUM_LINES-1:0]       lvl_i,
  input  logic [NUM_LINES-1:0]       pend_i,
  input  logic [NUM_LINES*CNT_W-1:0] cnt_flat_i,
  output logic [NUM_LINES-1:0]       mask_q_o,
  output logic [NUM_LINES-1:0]       mask_d_o,
  output logic [NUM_LINES-1:0]       ack_o,
  output logic [DATA_W-1:0]          rdata_o
);
  logic [NUM_LINES-1:0] mask_q;
  logic [NUM_LINES-1:0] mask_d;
  reg_sel_e             sel;

  always_comb begin
    if (addr_i == ADDR_W'(ADDR_MASK))       sel = SEL_MASK;
    else if (addr_i == ADDR_W'(ADDR_PEND))  sel = SEL_PEND;
    else if (addr_i == ADDR_W'(ADDR_LEVEL)) sel = SEL_LEVEL;
    else                                    sel = SEL_NONE;
  end

  always_comb begin
    mask_d = mask_q;
    ack_o  = '0;
    if (wr_en_i) begin
      if (sel == SEL_MASK) mask_d = wdata_i[NUM_LINES-1:0];
      if (sel == SEL_PEND) ack_o  = wdata_i[NUM_LINES-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else         mask_q <= mask_d;
  end

  always_comb begin
    rdata_o = '0;
    unique case (sel)
      SEL_MASK:  rdata_o = DATA_W'(mask_q);
      SEL_PEND:  rdata_o = DATA_W'(pend_i);
      SEL_LEVEL: rdata_o = DATA_W'(lvl_i);
      default: begin
        for (int i = 0; i < NUM_LINES; i++) begin
          if (addr_i == ADDR_W'(CNT_BASE + i))
            rdata_o = DATA_W'(cnt_flat_i[i*CNT_W +: CNT_W]);
        end
      end
    endcase
  end

  assign mask_q_o = mask_q;
  assign mask_d_o = mask_d;
endmodule

// File: rtl/lvl_sticky_intc.sv
module lvl_sticky_intc #(
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] req_i,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic                 irq_o
);
  localparam int unsigned CNT_BITS = NUM_LINES * CNT_W;

  logic [NUM_LINES-1:0] lvl_q;
  logic [NUM_LINES-1:0] pend_q;
  logic [NUM_LINES-1:0] pend_d;
  logic [NUM_LINES-1:0] rise;
  logic [NUM_LINES-1:0] ack;
  logic [NUM_LINES-1:0] mask_q;
  logic [NUM_LINES-1:0] mask_d;
  logic [CNT_BITS-1:0]  cnt_flat;
  logic                 irq_q;

  lsic_line_state #(.NUM_LINES(NUM_LINES)) i_lines (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .ack_i    (ack),
    .lvl_q_o  (lvl_q),
    .pend_q_o (pend_q),
    .pend_d_o (pend_d),
    .rise_o   (rise)
  );

  lsic_event_counters #(.NUM_LINES(NUM_LINES), .CNT_W(CNT_W)) i_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rise_i     (rise),
    .cnt_flat_o (cnt_flat)
  );

  lsic_reg_port #(
    .NUM_LINES (NUM_LINES),
    .CNT_W     (CNT_W),
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W)
  ) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .lvl_i      (lvl_q),
    .pend_i     (pend_q),
    .cnt_flat_i (cnt_flat),
    .mask_q_o   (mask_q),
    .mask_d_o   (mask_d),
    .ack_o      (ack),
    .rdata_o    (rdata_o)
  );

  // Output follows the next-state words so it lines up with the registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(pend_d & mask_d);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/lsic_checker.sv
module lsic_checker
  import lsic_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 6
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [NUM_LINES-1:0]       req_i,
  input logic                       wr_en_i,
  input logic [ADDR_W-1:0]          addr_i,
  input logic [DATA_W-1:0]          wdata_i,
  input logic                       irq_o,
  input logic [NUM_LINES-1:0]       mask_q,
  input logic [NUM_LINES-1:0]       pend_q,
  input logic [NUM_LINES-1:0]       lvl_q,
  input logic [NUM_LINES*CNT_W-1:0] cnt_flat
);
  logic             ack_wr;
  logic             mask_wr;
  logic [CNT_W-1:0] cnt0;

  assign ack_wr  = wr_en_i && (addr_i == ADDR_W'(ADDR_PEND));
  assign mask_wr = wr_en_i && (addr_i == ADDR_W'(ADDR_MASK));
  assign cnt0    = cnt_flat[CNT_W-1:0];

  assert_level_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> lvl_q == $past(req_i));

  assert_pending_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(ack_wr)) |-> ((pend_q & $past(pend_q)) == $past(pend_q)));

  assert_irq_matches_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == |(pend_q & mask_q));

  assert_mask_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(mask_wr)) |-> mask_q == $past(wdata_i[NUM_LINES-1:0]));

  assert_ack_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(ack_wr)) |->
      ((pend_q & $past(wdata_i[NUM_LINES-1:0]) & ~$past(req_i)) == '0));

  assert_held_stays_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q & lvl_q) == lvl_q);

  assert_count_rise_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(req_i[0]) && !$past(lvl_q[0])) |->
      cnt0 == $past(cnt0) + CNT_W'(1));

  assert_count_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !($past(req_i[0]) && !$past(lvl_q[0]))) |->
      cnt0 == $past(cnt0));
endmodule

bind lvl_sticky_intc lsic_checker #(
  .NUM_LINES (NUM_LINES),
  .CNT_W     (CNT_W),
  .DATA_W    (DATA_W),
  .ADDR_W    (ADDR_W)
) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .wr_en_i  (wr_en_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .irq_o    (irq_o),
  .mask_q   (mask_q),
  .pend_q   (pend_q),
  .lvl_q    (lvl_q),
  .cnt_flat (cnt_flat)
);

// File: tb/test_lvl_sticky_intc.sv
`timescale 1ns/1ps
module test_lvl_sticky_intc;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] req;
  logic        wr_en;
  logic [5:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  lvl_sticky_intc i_lvl_sticky_intc (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .req_i   (req),
    .wr_en_i (wr_en),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .irq_o   (irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wreg(input logic [5:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    step();
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd_check(input string tag, input logic [5:0] a, input logic [31:0] exp);
    addr = a;
    #0.5;
    check(tag, rdata, exp);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  task automatic t_reset();
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
    rd_check("R1 mask reset", 6'd0, 32'h0);
    rd_check("R1 pending reset", 6'd1, 32'h0);
    rd_check("R1 level reset", 6'd2, 32'h0);
    rd_check("R1 counter 0 reset", 6'd32, 32'h0);
    rd_check("R1 counter 31 reset", 6'd63, 32'h0);
  endtask

  task automatic t_level();
    req = 32'hA5A5_0F0F;
    step();
    rd_check("R2 level follows", 6'd2, 32'hA5A5_0F0F);
    rd_check("R3 pending set", 6'd1, 32'hA5A5_0F0F);
    req = 32'h0;
    step();
    rd_check("R2 level drops", 6'd2, 32'h0);
    rd_check("R3 pending sticky", 6'd1, 32'hA5A5_0F0F);
  endtask

  task automatic t_mask_irq();
    check("R4 masked pending no irq", {31'b0, irq}, 32'h0);
    wreg(6'd0, 32'h0000_0001);
    check("R4 irq after mask hit", {31'b0, irq}, 32'h1);
    rd_check("R5 mask readback", 6'd0, 32'h0000_0001);
    wreg(6'd0, 32'h0000_0010);
    check("R4 irq after mask miss", {31'b0, irq}, 32'h0);
    rd_check("R5 mask replaced", 6'd0, 32'h0000_0010);
  endtask

  task automatic t_ack();
    wreg(6'd1, 32'h0000_000F);
    rd_check("R6 ack clears low lines", 6'd1, 32'hA5A5_0F00);
    req = 32'h0000_0100;
    step();
    wreg(6'd1, 32'h0000_0100);
    rd_check("R7 ack of held line", 6'd1, 32'hA5A5_0F00);
    req = 32'h0010_0100;
    wreg(6'd1, 32'h0010_0000);
    rd_check("R7 ack with same-cycle rise", 6'd1, 32'hA5B5_0F00);
    wreg(6'd0, 32'h0000_0100);
    check("R4 irq from held line", {31'b0, irq}, 32'h1);
    req = 32'h0;
    wreg(6'd1, 32'h0000_0100);
    rd_check("R6 ack after line drops", 6'd1, 32'hA5B5_0E00);
    check("R4 irq drops after ack", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_count();
    req = 32'h0;
    rst_n = 1'b0;
    step();
    step();
    rst_n = 1'b1;
    rd_check("R1 pending after second reset", 6'd1, 32'h0);
    rd_check("R1 mask after second reset", 6'd0, 32'h0);
    req = 32'h0000_0008;
    step(); step(); step();
    req = 32'h0;
    step();
    req = 32'h0000_0008;
    step();
    req = 32'h8000_0008;
    step();
    req = 32'h0;
    step();
    rd_check("R8 line 3 two rises", 6'd35, 32'd2);
    rd_check("R8 line 31 one rise", 6'd63, 32'd1);
    rd_check("R8 idle line 0", 6'd32, 32'd0);
  endtask

  task automatic t_ignore();
    req = 32'h0000_0005;
    wreg(6'd2, 32'hFFFF_FFFF);
    rd_check("R9 level write ignored", 6'd2, 32'h0000_0005);
    wreg(6'd35, 32'h0);
    rd_check("R9 counter write ignored", 6'd35, 32'd2);
    rd_check("R9 unmapped read 5", 6'd5, 32'h0);
    rd_check("R9 unmapped read 31", 6'd31, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; req = '0; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_level();
    t_mask_irq();
    t_ack();
    t_count();
    t_ignore();
    done = 1'b1;
    report();
  end

  initial begin
    #400000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end
endmodule